// File: doc/BRIEF.md
# Cascade FFT Sequence Controller

This block sequences a radix-2 cascade FFT of N = 2^M points from one binary word counter. The counter moves forward by one each time a complex input word is strobed in and wraps without a gap, so blocks follow one another with no pause. Each of the M stages receives a route bit (fill its delay line, or compute the butterfly) and a twiddle table address. Both come from the count of the word that stage is handling at that moment. A one-word register sits between adjacent stages. For that reason the control for stage s is built from the count of the word strobed s-1 words earlier, and the count for stage 1 is the live value.

A runtime selector picks how many interleaved channels the stream carries, L = 2^c. The output is then taken after stage t = M - c. Each result at that tap is tagged with its channel and its frequency. The channel is the low c bits of the tap's word count. The frequency is the upper t bits of that count, read in reversed bit order. Datapath, delay memories and twiddle values are outside this block.

Top module: `fft_seq_ctrl`

## Requirements
- R1: `word_cnt_o` advances by exactly one on each clock edge where `in_valid` is high, and it holds its value on every other edge.
- R2: The count wraps from N-1 to 0 on the next strobe, with no idle count in between.
- R3: Stage s (1..M) has a route bit `sw_o[s-1]` equal to bit M-s of that stage's word count. The value 1 means compute and 0 means fill.
- R4: The word count for stage s is the count of the word strobed s-1 strobes earlier. Stage 1 uses the live count. A stage that has not yet seen that many strobes since reset uses 0.
- R5: The twiddle address of stage s is an (M-1)-bit field at `tw_o[(s-1)*(M-1) +: M-1]`. It is formed by taking the top s-1 bits of the stage count, reversing them over s-1 bits, and shifting the result left by M-s. As a consequence, stage 1 is always 0 and stage 2 is always 0 or N/4.
- R6: With channel selector c, the tap stage is t = M-c. The tap count is the count of the word strobed t strobes earlier, or 0 when fewer than t strobes have been seen. `tag_chan_o` is the low c bits of the tap count. `tag_freq_o` is the tap count shifted right by c and then bit-reversed over t bits.
- R7: A selector value above M-1 behaves exactly as M-1.
- R8: A synchronous reset clears the counter and every alignment register, so that all counts, route bits, twiddle addresses and tags read 0.
- R9: While `in_valid` is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: one complex word enters this cycle |
| chan_log2_i | input | $clog2(M)+1 | log2 of the interleaved channel count |
| word_cnt_o | output | M | Live word count (count of the word now entering) |
| sw_o | output | M | Per-stage route bit, stage s at bit s-1 |
| tw_o | output | M*(M-1) | Per-stage twiddle address, stage s in slice s-1 |
| tag_chan_o | output | M | Channel number of the current tap output |
| tag_freq_o | output | M | Frequency index of the current tap output |

## Verification
The bench builds the block with M = 4, which gives a 16-point transform with four stages. At that size the wrap is reached within sixteen strobes, and every stage's alignment delay is crossed well inside one block. Because the selector is three bits wide, all four tap choices (one to eight channels) can be driven, and so can out-of-range values that must clamp. Gapped strobe patterns show that the counter and the alignment chain stand still between words, and mid-run resets show the return to the start of a block.

// File: rtl/fftc_pkg.sv
package fftc_pkg;

  // Reverse the low n bits of v; bits at and above n are returned as zero.
  function automatic logic [31:0] bit_rev(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) r[i] = v[n-1-i];
    end
    return r;
  endfunction

  // Twiddle index (in units of the N-point root) for stage s of an m-stage cascade.
  function automatic logic [31:0] twiddle_index(input logic [31:0] c, input int m, input int s);
    logic [31:0] upper;
    upper = c >> (m - s + 1);
    return bit_rev(upper, s - 1) << (m - s);
  endfunction

  // Channel field: the low cb bits of the tap count.
  function automatic logic [31:0] chan_field(input logic [31:0] c, input int cb);
    return c & ((32'd1 << cb) - 32'd1);
  endfunction

  // Frequency field: the bits above the channel field, reversed over their width.
  function automatic logic [31:0] freq_field(input logic [31:0] c, input int m, input int cb);
    return bit_rev(c >> cb, m - cb);
  endfunction

endpackage

// File: rtl/fftc_word_counter.sv
module fftc_word_counter #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [M-1:0] cnt_o
);
  logic [M-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fftc_align_chain.sv
module fftc_align_chain #(
  parameter int M     = 4,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [M-1:0]       head_i,
  output logic [DEPTH*M-1:0] taps_o
);
  logic [M-1:0] dq [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_reg
    logic [M-1:0] src;
    if (j == 0) begin : g_first
      assign src = head_i;
    end else begin : g_next
      assign src = dq[j-1];
    end
    always_ff @(posedge clk) begin
      if (rst)       dq[j] <= '0;
      else if (step) dq[j] <= src;
    end
    assign taps_o[j*M +: M] = dq[j];
  end
endmodule

// File: rtl/fftc_stage_ctrl.sv
module fftc_stage_ctrl #(
  parameter int M = 4,
  parameter int S = 1
) (
  input  logic [M-1:0] stage_cnt_i,
  output logic         sw_o,
  output logic [M-2:0] tw_o
);
  localparam int TWW = M - 1;

  assign sw_o = stage_cnt_i[M-S];
  assign tw_o = TWW'(fftc_pkg::twiddle_index(32'(stage_cnt_i), M, S));
endmodule

// File: rtl/fftc_tagger.sv
module fftc_tagger #(
  parameter int M    = 4,
  parameter int SELW = 3
) (
  input  logic [M*M-1:0]  taps_i,
  input  logic [SELW-1:0] chan_log2_i,
  output logic [SELW-1:0] cb_eff_o,
  output logic [M-1:0]    chan_o,
  output logic [M-1:0]    freq_o
);
  logic [SELW-1:0] cb;
  logic [M-1:0]    tap_cnt;
  int              tap_stage;

  always_comb begin
    if (32'(chan_log2_i) > M - 1) cb = SELW'(M - 1);
    else                          cb = chan_log2_i;
  end

  always_comb begin
    tap_stage = M - int'(cb);
    tap_cnt   = '0;
    for (int j = 1; j <= M; j++) begin
      if (j == tap_stage) tap_cnt = taps_i[(j-1)*M +: M];
    end
  end

  assign cb_eff_o = cb;
  assign chan_o   = M'(fftc_pkg::chan_field(32'(tap_cnt), int'(cb)));
  assign freq_o   = M'(fftc_pkg::freq_field(32'(tap_cnt), M, int'(cb)));
endmodule

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl #(
  parameter  int M    = 4,
  localparam int N    = 1 << M,
  localparam int TWW  = M - 1,
  localparam int SELW = $clog2(M) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SELW-1:0]   chan_log2_i,
  output logic [M-1:0]      word_cnt_o,
  output logic [M-1:0]      sw_o,
  output logic [M*TWW-1:0]  tw_o,
  output logic [M-1:0]      tag_chan_o,
  output logic [M-1:0]      tag_freq_o
);
  // Named internal events for the checker
  logic [M-1:0]    cnt_now;
  logic [M*M-1:0]  taps_flat;
  logic [M*M-1:0]  stg_cnt_flat;
  logic [SELW-1:0] cb_eff;
  logic            wrap_ev;

  fftc_word_counter #(.M(M)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (in_valid),
    .cnt_o (cnt_now)
  );

  fftc_align_chain #(.M(M), .DEPTH(M)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid),
    .head_i (cnt_now),
    .taps_o (taps_flat)
  );

  for (genvar s = 1; s <= M; s++) begin : g_stage
    if (s == 1) begin : g_live
      assign stg_cnt_flat[0 +: M] = cnt_now;
    end else begin : g_dly
      assign stg_cnt_flat[(s-1)*M +: M] = taps_flat[(s-2)*M +: M];
    end
    fftc_stage_ctrl #(.M(M), .S(s)) u_ctl (
      .stage_cnt_i (stg_cnt_flat[(s-1)*M +: M]),
      .sw_o        (sw_o[s-1]),
      .tw_o        (tw_o[(s-1)*TWW +: TWW])
    );
  end

  fftc_tagger #(.M(M), .SELW(SELW)) u_tag (
    .taps_i      (taps_flat),
    .chan_log2_i (chan_log2_i),
    .cb_eff_o    (cb_eff),
    .chan_o      (tag_chan_o),
    .freq_o      (tag_freq_o)
  );

  assign wrap_ev    = in_valid && (cnt_now == M'(N - 1));
  assign word_cnt_o = cnt_now;
endmodule

// File: rtl/fft_seq_ctrl_chk.sv
module fft_seq_ctrl_chk #(
  parameter int M    = 4,
  parameter int TWW  = 3,
  parameter int SELW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             wrap_ev,
  input logic [M-1:0]     cnt_now,
  input logic [M*M-1:0]   stg_cnt_flat,
  input logic [M-1:0]     sw_o,
  input logic [M*TWW-1:0] tw_o,
  input logic [M-1:0]     tag_chan_o,
  input logic [SELW-1:0]  cb_eff
);
  localparam logic [M-1:0] HALF_M1 = M'((1 << (M - 1)) - 1);

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> cnt_now == M'($past(cnt_now) + 1'b1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_ev |=> cnt_now == '0);

  p_route_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_now == HALF_M1) |=> sw_o[0]);

  for (genvar s = 1; s < M; s++) begin : g_align
    p_align_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> stg_cnt_flat[s*M +: M] == $past(stg_cnt_flat[(s-1)*M +: M]));
  end

  p_tw_first_r5: assert property (@(posedge clk) disable iff (rst)
    tw_o[0 +: TWW] == '0 && $countones(tw_o[TWW +: TWW]) <= 1);

  p_chan_range_r6: assert property (@(posedge clk) disable iff (rst)
    (32'(tag_chan_o) >> cb_eff) == 0);

  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    32'(cb_eff) <= M - 1);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (cnt_now == '0 && stg_cnt_flat == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cnt_now) && $stable(stg_cnt_flat)));
endmodule

bind fft_seq_ctrl fft_seq_ctrl_chk #(.M(M), .TWW(TWW), .SELW(SELW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .wrap_ev      (wrap_ev),
  .cnt_now      (cnt_now),
  .stg_cnt_flat (stg_cnt_flat),
  .sw_o         (sw_o),
  .tw_o         (tw_o),
  .tag_chan_o   (tag_chan_o),
  .cb_eff       (cb_eff)
);

// File: tb/fft_seq_ctrl_tb.sv
module fft_seq_ctrl_tb;
  localparam int M    = 4;
  localparam int N    = 1 << M;
  localparam int TWW  = M - 1;
  localparam int SELW = $clog2(M) + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [SELW-1:0]   chan_log2_i = '0;
  logic [M-1:0]      word_cnt_o;
  logic [M-1:0]      sw_o;
  logic [M*TWW-1:0]  tw_o;
  logic [M-1:0]      tag_chan_o;
  logic [M-1:0]      tag_freq_o;

  int n_chk  = 0;
  int n_fail = 0;
  int w      = 0;   // strobes since last reset
  bit done   = 0;

  always #5 clk = ~clk;

  fft_seq_ctrl #(.M(M)) u_dut (
    .clk, .rst, .in_valid, .chan_log2_i,
    .word_cnt_o, .sw_o, .tw_o, .tag_chan_o, .tag_freq_o
  );

  function automatic int rev(int v, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (((v >> i) & 1) != 0) r = r | (1 << (n - 1 - i));
    return r;
  endfunction

  // Count seen by something delayed by d strobes
  function automatic int seen(int d);
    return (w >= d) ? ((w - d) % N) : 0;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (strobes=%0d)", req, what, act, exp, w);
    end
  endtask

  // Compare every output against the model for the current word
  task automatic check_all(int sel);
    int cb, t, tc;
    cmp("R1", "word_cnt", int'(word_cnt_o), w % N);
    for (int s = 1; s <= M; s++) begin
      int sc = seen(s - 1);
      int etw = rev(sc >> (M - s + 1), s - 1) << (M - s);
      cmp(s == 1 ? "R3" : "R4", $sformatf("sw stage%0d", s), int'(sw_o[s-1]), (sc >> (M - s)) & 1);
      cmp("R5", $sformatf("tw stage%0d", s), int'(tw_o[(s-1)*TWW +: TWW]), etw);
    end
    cb = (sel > M - 1) ? M - 1 : sel;
    t  = M - cb;
    tc = seen(t);
    cmp(sel > M - 1 ? "R7" : "R6", "tag_chan", int'(tag_chan_o), tc & ((1 << cb) - 1));
    cmp(sel > M - 1 ? "R7" : "R6", "tag_freq", int'(tag_freq_o), rev(tc >> cb, t));
  endtask

  task automatic word(bit v, int sel);
    @(negedge clk);
    in_valid    = v;
    chan_log2_i = SELW'(sel);
    #1;
    check_all(sel);
    @(posedge clk);
    if (v) w++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    w = 0;
    #1;
    cmp("R8", "word_cnt", int'(word_cnt_o), 0);
    cmp("R8", "sw", int'(sw_o), 0);
    cmp("R8", "tw", int'(tw_o), 0);
    cmp("R8", "tag_chan", int'(tag_chan_o), 0);
    cmp("R8", "tag_freq", int'(tag_freq_o), 0);
  endtask

  task automatic t_single_channel();   // R1 R2 R3 R5 R6, c = 0
    for (int i = 0; i < 3 * N; i++) word(1'b1, 0);
  endtask

  task automatic t_all_taps();         // R6 for c = 1..3
    for (int c = 1; c < M; c++)
      for (int i = 0; i < N + 5; i++) word(1'b1, c);
  endtask

  task automatic t_gapped();           // R9 R4: idle words leave everything still
    for (int i = 0; i < 2 * N; i++) word((i % 3) != 0, i % M);
  endtask

  task automatic t_clamp();            // R7: selectors above M-1
    for (int i = 0; i < N + 3; i++) word(1'b1, 4 + (i % 4));
  endtask

  task automatic t_midrun_reset();     // R8 after partial block
    for (int i = 0; i < 7; i++) word(1'b1, 1);
    do_reset();
    for (int i = 0; i < 6; i++) word(1'b1, 2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset();
    t_single_channel();
    t_all_taps();
    t_gapped();
    t_clamp();
    t_midrun_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule